// File: doc/BRIEF.md
# Bidirectional AES byte substitution unit

This unit maps one byte through either the forward AES substitution or its inverse. A 1-bit mode pin chooses the direction for each transfer. The forward substitution is computed arithmetically: the byte is inverted in GF(2^8) under the polynomial x^8+x^4+x^3+x+1, with zero mapped to zero, and the result goes through the affine map with constant 0x63. There is a single forward core. The inverse direction reuses it by placing an inverse-affine stage in front of the core and another behind it. Each output bit i of an inverse-affine stage is the XOR of input bits (i+2), (i+5) and (i+7) mod 8, and of bit i of the constant 0x05. The trailing stage cancels the affine step at the end of the core.

The parameter SHARED picks the variant. With SHARED=0 there are two inverse-affine stages, and both directions are purely combinational. With SHARED=1 (the default) there is one inverse-affine stage. A decrypt request passes through that stage and the core, and the core's result is caught in a holding register. On the next cycle the held byte passes through the same stage again.

Bytes arrive and leave on valid/ready streams:
- The input is accepted on a cycle where in_valid and in_ready are both high.
- The output is taken on a cycle where out_valid and out_ready are both high.
- While out_valid is high and out_ready is low, the source must hold in_valid, in_inv and in_byte, and the output stays unchanged.
- The unit never raises in_ready while out_ready is low.

Top module: `bidir_subst`

## Requirements
- R1: With in_inv=0, out_byte is the AES forward substitution of in_byte. out_valid is high in the same cycle as the accepted input, in both variants.
- R2: With in_inv=1, out_byte is the inverse AES substitution of in_byte, so feeding S(x) returns x for every byte x. With SHARED=0 the result appears in the same cycle. With SHARED=1, out_valid is low in the accept cycle and high in the following cycle with the result.
- R3: The mode encoding is in_inv=0 for forward and in_inv=1 for inverse. For the same byte 0x63, forward gives 0xFB and inverse gives 0x00.
- R4: Zero has no field inverse and maps to zero, so forward of 0x00 is 0x63 and inverse of 0x63 is 0x00.
- R5: No result equals its input byte or the bitwise complement of its input byte, in either direction.
- R6: While out_ready is low, in_ready is low. A valid output that is not taken stays valid with the same out_byte on the next cycle.
- R7: With SHARED=1, while a decrypt result is held, in_ready stays low. A new byte offered then does not change out_byte. The held result is released on the first cycle where out_ready is high.
- R8: After reset with SHARED=1, with in_valid low: out_valid is low and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding register (shared variant) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Unit accepts the offered byte this cycle |
| in_inv | input | 1 | Direction: 0 forward, 1 inverse |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | out_byte holds a result |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
Forward results, and inverse results in the combinational variant, are due in the same cycle as the input: the bench drives the input after a falling edge and samples a moment later, before the next rising edge. An inverse result in the shared variant is due one rising edge after acceptance. For that case the bench checks that out_valid is low in the accept cycle, then samples the output in the half-cycle after the next falling edge. Stall cases keep out_ready low across several edges and re-sample at each falling edge, to confirm the held byte and the low in_ready.

// File: rtl/subst_pkg.sv
package subst_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t FIELD_RED  = 8'h1B;
  localparam byte_t FWD_CONST  = 8'h63;
  localparam byte_t FWD_TAPS   = 8'b1111_0001;
  localparam byte_t UNAFF_CONST = 8'h05;
  localparam byte_t UNAFF_TAPS = 8'b1010_0100;

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? byte_t'((sh << 1) ^ FIELD_RED) : byte_t'(sh << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/xor_tap_map.sv
module xor_tap_map
  import subst_pkg::*;
#(
  parameter byte_t TAPS  = FWD_TAPS,
  parameter byte_t CONST = FWD_CONST
) (
  input  byte_t din,
  output byte_t dout
);
  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      logic acc;
      acc = CONST[i];
      for (int k = 0; k < BYTE_W; k++) begin
        int unsigned idx;
        idx = (i + k) % BYTE_W;
        if (TAPS[k]) acc = acc ^ din[idx[IDX_W-1:0]];
      end
      dout[i] = acc;
    end
  end
endmodule

// File: rtl/gf_inverse.sv
module gf_inverse
  import subst_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  byte_t p2, p3, p6, p12, p15, p30, p60, p120, p240, p252;

  always_comb begin
    p2   = gf_mul(din, din);
    p3   = gf_mul(p2, din);
    p6   = gf_mul(p3, p3);
    p12  = gf_mul(p6, p6);
    p15  = gf_mul(p12, p3);
    p30  = gf_mul(p15, p15);
    p60  = gf_mul(p30, p30);
    p120 = gf_mul(p60, p60);
    p240 = gf_mul(p120, p120);
    p252 = gf_mul(p240, p12);
    dout = gf_mul(p252, p2);
  end
endmodule

// File: rtl/fwd_core.sv
module fwd_core
  import subst_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  byte_t inv_b;

  gf_inverse u_inv (.din(din), .dout(inv_b));

  xor_tap_map #(.TAPS(FWD_TAPS), .CONST(FWD_CONST)) u_aff (
    .din(inv_b), .dout(dout)
  );
endmodule

// File: rtl/bidir_subst.sv
module bidir_subst
  import subst_pkg::*;
#(
  parameter bit SHARED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_inv,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte
);
  byte_t core_in, core_out;

  fwd_core u_core (.din(core_in), .dout(core_out));

  if (SHARED) begin : g_shared
    logic  hold_q;
    byte_t hold_d;
    byte_t ua_in, ua_out;

    assign ua_in = hold_q ? hold_d : in_byte;

    xor_tap_map #(.TAPS(UNAFF_TAPS), .CONST(UNAFF_CONST)) u_ua (
      .din(ua_in), .dout(ua_out)
    );

    assign core_in   = in_inv ? ua_out : in_byte;
    assign in_ready  = !hold_q && out_ready;
    assign out_valid = hold_q || (in_valid && !in_inv);
    assign out_byte  = hold_q ? ua_out : core_out;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= 1'b0;
        hold_d <= '0;
      end else if (!hold_q) begin
        if (in_valid && in_ready && in_inv) begin
          hold_q <= 1'b1;
          hold_d <= core_out;
        end
      end else if (out_ready) begin
        hold_q <= 1'b0;
      end
    end
  end else begin : g_dual
    byte_t pre_out, post_out;

    xor_tap_map #(.TAPS(UNAFF_TAPS), .CONST(UNAFF_CONST)) u_pre (
      .din(in_byte), .dout(pre_out)
    );
    xor_tap_map #(.TAPS(UNAFF_TAPS), .CONST(UNAFF_CONST)) u_post (
      .din(core_out), .dout(post_out)
    );

    assign core_in   = in_inv ? pre_out : in_byte;
    assign out_byte  = in_inv ? post_out : core_out;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end
endmodule

// File: rtl/subst_checker.sv
module subst_checker #(
  parameter bit SHARED = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_inv,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  a_r1_fwd_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_inv |-> out_valid);

  a_r4_zero_maps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_inv && in_byte == 8'h00 |-> out_byte == 8'h63);

  a_r5_no_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_valid |-> out_byte != in_byte && out_byte != ~in_byte);

  always_comb begin
    if (rst_n && !out_ready) a_r6_ready_follows: assert (!in_ready);
  end

  if (SHARED) begin : g_sh
    a_r2_inv_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_inv |=> out_valid && !in_ready);

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte));

    a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !in_ready && !(in_valid && !in_inv) |=> !in_ready);
  end
endmodule

bind bidir_subst subst_checker #(.SHARED(SHARED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_inv(in_inv), .in_byte(in_byte), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/sim_bidir_subst.sv
module sim_bidir_subst;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       vi, ri, inv, vo, ro;
  logic [7:0] bi, bo;
  logic       c_vi, c_ri, c_inv, c_vo, c_ro;
  logic [7:0] c_bi, c_bo;

  bidir_subst #(.SHARED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vi), .in_ready(ri), .in_inv(inv),
    .in_byte(bi), .out_valid(vo), .out_ready(ro), .out_byte(bo)
  );
  bidir_subst #(.SHARED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(c_vi), .in_ready(c_ri), .in_inv(c_inv),
    .in_byte(c_bi), .out_valid(c_vo), .out_ready(c_ro), .out_byte(c_bo)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] sb [256];
  logic [7:0] isb [256];

  function automatic logic [7:0] bench_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] bench_rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (bench_mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      sb[x] = iv ^ bench_rotl(iv, 1) ^ bench_rotl(iv, 2) ^ bench_rotl(iv, 3)
            ^ bench_rotl(iv, 4) ^ 8'h63;
    end
    for (int x = 0; x < 256; x++) isb[sb[x]] = 8'(x);

    vi = 0; inv = 0; bi = 0; ro = 1;
    c_vi = 0; c_inv = 0; c_bi = 0; c_ro = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R8 out_valid after reset", {7'd0, vo}, 8'd0);
    check("R8 in_ready after reset", {7'd0, ri}, 8'd1);
    ro = 0; #1;
    check("R8 in_ready follows out_ready", {7'd0, ri}, 8'd0);
    ro = 1;

    // combinational variant: all bytes, both directions
    for (int x = 0; x < 256; x++) begin
      c_vi = 1; c_inv = 0; c_bi = 8'(x); #1;
      check("R1 dual fwd", c_bo, sb[x]);
      check("R1 dual valid", {7'd0, c_vo}, 8'd1);
      c_inv = 1; c_bi = sb[x]; #1;
      check("R2 dual inverse round-trip", c_bo, 8'(x));
      c_ro = 0; #1;
      check("R6 dual ready low", {7'd0, c_ri}, 8'd0);
      c_ro = 1;
    end
    c_vi = 0;

    // shared variant: forward sweep
    for (int x = 0; x < 256; x++) begin
      @(negedge clk);
      vi = 1; inv = 0; bi = 8'(x); #1;
      check("R1 shared fwd valid", {7'd0, vo}, 8'd1);
      check("R1 shared fwd", bo, sb[x]);
      if (bo == 8'(x) || bo == ~8'(x)) check("R5 fixed point", bo, ~bo);
    end
    // shared variant: inverse sweep with round trip
    for (int x = 0; x < 256; x++) begin
      @(negedge clk);
      vi = 1; inv = 1; bi = sb[x]; #1;
      check("R2 accept cycle no valid", {7'd0, vo}, 8'd0);
      @(negedge clk);
      vi = 0; #1;
      check("R2 next cycle valid", {7'd0, vo}, 8'd1);
      check("R2 shared inverse round-trip", bo, 8'(x));
      if (bo == sb[x] || bo == ~sb[x]) check("R5 fixed point inv", bo, ~bo);
    end

    // R3 and R4 corner values
    @(negedge clk);
    vi = 1; inv = 0; bi = 8'h63; #1;
    check("R3 fwd of 63", bo, 8'hFB);
    bi = 8'h00; #1;
    check("R4 fwd of 00", bo, 8'h63);
    @(negedge clk);
    inv = 1; bi = 8'h63; #1;
    @(negedge clk);
    vi = 0; #1;
    check("R3 R4 inv of 63", bo, 8'h00);

    // R6 forward stall
    @(negedge clk);
    vi = 1; inv = 0; bi = 8'h53; ro = 0; #1;
    check("R6 stall ready low", {7'd0, ri}, 8'd0);
    check("R6 stall value", bo, 8'hED);
    repeat (2) begin
      @(negedge clk); #1;
      check("R6 stall held valid", {7'd0, vo}, 8'd1);
      check("R6 stall held value", bo, 8'hED);
    end
    ro = 1;

    // R7 held inverse result ignores new input
    @(negedge clk);
    vi = 1; inv = 1; bi = 8'hED; #1;
    @(negedge clk);
    inv = 0; bi = 8'h11; ro = 0; #1;
    check("R7 held value", bo, 8'h53);
    check("R7 ready low", {7'd0, ri}, 8'd0);
    repeat (2) begin
      @(negedge clk); #1;
      check("R7 still held", bo, 8'h53);
      check("R7 still valid", {7'd0, vo}, 8'd1);
    end
    ro = 1; #1;
    check("R7 release value", bo, 8'h53);
    @(negedge clk); #1;
    check("R7 new byte after release", bo, sb[8'h11]);
    check("R7 ready after release", {7'd0, ri}, 8'd1);
    @(negedge clk);
    vi = 0;
    @(negedge clk);
    finish_run();
  end
endmodule